// File: doc/BRIEF.md
# Boot Bus-Width Detection Sequencer

This block brings a processor out of reset from an external parallel NOR flash or ROM whose data width is not known in advance. When the boot-strap input is low during reset, the block enables the boot chip-select area and leaves it at the default 16-bit width. It then runs a fixed series of read cycles on a simple asynchronous bus. Two dummy reads come first. The vector word is then probed at 16-bit width, and bit 0 of its lower halfword acts as an in-band width flag.

Once the flag sets the width, the block reads the 32-bit vector again at that width. It puts the assembled value on the jump-target output and issues the first two instruction fetches at the target and at the target plus two. It then pulses done for one clock. The width setting and the target stay frozen until the next reset. When the strap is high during reset, the block never drives the bus.

Top module: `boot_width_seq`

## Requirements
- R1: If `boot_strap` is 1 while `rst` is high, the block stays idle after reset. `bus_cs_n` stays 1, `done` never pulses and `area_en` stays 0. This holds even if the strap changes later.
- R2: While `rst` is high, `width8` is 0 (16-bit) and `area_en` is 0. When the sequence runs, `area_en` is 1 before the first read cycle starts.
- R3: The first two reads go to addresses 0x00C00000 and then 0x00C00002, and their data is discarded.
- R4: The probe reads follow, as halfword reads at 0x20000000 and then 0x20000002.
- R5: After the probe, `width8` becomes bus_din bit 0 from the read at 0x20000000, with 1 meaning 8-bit and 0 meaning 16-bit. It never returns to 0 before reset.
- R6: In 8-bit mode the vector is re-read at 0x20000000, 0x20000001, 0x20000002 and 0x20000003, taking bus_din[7:0] only. The byte from the lowest address lands in `jump_addr[7:0]` and the byte from the highest in `jump_addr[31:24]`.
- R7: In 16-bit mode the vector is re-read at 0x20000000 and 0x20000002. The lower address gives `jump_addr[15:0]` and the upper gives `jump_addr[31:16]`.
- R8: Two fetch reads follow, at the target P and then at P+2. P includes its bit 0 exactly as read.
- R9: After the second fetch, `done` is high for exactly one clock. From then until reset, `jump_addr` and `width8` hold still and no more bus cycles occur.
- R10: In every read, `bus_cs_n` and `bus_rd_n` fall and rise together, stay low for exactly LOW_CYC clocks, and hold `bus_addr` steady. Consecutive reads in a sequence are separated by exactly one high clock.
- R11: A reset asserted partway through a sequence restarts it from the first dummy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 1 | Sampled during reset; 0 runs the boot sequence |
| bus_cs_n | output | 1 | Chip select for the boot area, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Byte address of the current read |
| bus_din | input | DATA_W | Read data from the external device |
| area_en | output | 1 | Boot chip-select area enabled |
| width8 | output | 1 | Area width: 0 = 16-bit, 1 = 8-bit |
| jump_addr | output | 32 | Assembled reset-vector target |
| done | output | 1 | One-clock pulse when the sequence completes |

## Verification
The bench models both device widths. An 8-bit device puts filler on the upper data lines, so a design that took the upper byte, or that ordered bytes big-endian, would produce a wrong target. The vector set includes a flag value of zero, an all-ones vector whose P+2 fetch wraps, and vectors whose only set bit is the flag. These catch a flag read from the wrong halfword, a flag stripped from the target, and a width that stays stuck at 16. Strobe timing and the single idle clock are measured on every read, so an extra or missing clock is caught. A reset partway through the re-read, and a high strap followed by a later low one, check that the sequence restarts cleanly and that the strap is sampled only during reset.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int VEC_W = 32;

  typedef enum logic [2:0] {
    ST_START,
    ST_DUMMY,
    ST_PROBE,
    ST_REREAD,
    ST_FETCH,
    ST_DONE,
    ST_OFF
  } seq_st_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LOW,
    ENG_GAP
  } eng_st_t;
endpackage

// File: rtl/boot_bus_reader.sv
module boot_bus_reader
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int LOW_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ready,
  output logic              ack,
  output logic [DATA_W-1:0] ack_data,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int CW = (LOW_CYC > 1) ? $clog2(LOW_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(LOW_CYC - 1);

  eng_st_t       phase;
  logic [CW-1:0] cnt;

  // A new access may start in the gap clock, giving exactly one idle clock.
  assign ready    = (phase != ENG_LOW);
  assign ack      = (phase == ENG_LOW) && (cnt == LAST_CNT);
  assign ack_data = bus_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ENG_IDLE;
      cnt      <= '0;
      bus_cs_n <= 1'b1;
      bus_rd_n <= 1'b1;
      bus_addr <= '0;
    end else if (ready && req) begin
      phase    <= ENG_LOW;
      cnt      <= '0;
      bus_cs_n <= 1'b0;
      bus_rd_n <= 1'b0;
      bus_addr <= req_addr;
    end else if (ack) begin
      phase    <= ENG_GAP;
      bus_cs_n <= 1'b1;
      bus_rd_n <= 1'b1;
    end else if (phase == ENG_LOW) begin
      cnt <= cnt + 1'b1;
    end else if (phase == ENG_GAP) begin
      phase <= ENG_IDLE;
    end
  end
endmodule

// File: rtl/boot_vec_collect.sv
module boot_vec_collect
  import boot_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              byte_mode,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] din,
  output logic [VEC_W-1:0]  vec
);
  localparam int LANES = VEC_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic hit;
    logic [7:0] src;
    // Byte mode: lane b takes D[7:0] on access b.
    // Halfword mode: lanes 2k and 2k+1 take D[7:0] and D[15:8] on access k.
    assign hit = byte_mode ? (idx == 2'(b)) : (idx[0] == 1'(b / 2));
    assign src = byte_mode ? din[7:0] : din[8*(b%2) +: 8];

    always_ff @(posedge clk) begin
      if (rst) vec[8*b +: 8] <= '0;
      else if (we && hit) vec[8*b +: 8] <= src;
    end
  end
endmodule

// File: rtl/boot_width_seq.sv
module boot_width_seq
  import boot_seq_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 16,
  parameter int          LOW_CYC    = 3,
  parameter logic [31:0] DUMMY_ADDR = 32'h00C0_0000,
  parameter logic [31:0] VEC_ADDR   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_strap,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              area_en,
  output logic              width8,
  output logic [VEC_W-1:0]  jump_addr,
  output logic              done
);
  seq_st_t           st;
  logic [1:0]        idx;
  logic              wait_q;
  logic              probe_bit;
  logic              run_q;
  logic              req, ready, ack, accept, access_st;
  logic [DATA_W-1:0] ack_data;
  logic [1:0]        last_idx;
  logic [31:0]       step_addr;

  assign access_st = (st == ST_DUMMY) || (st == ST_PROBE) ||
                     (st == ST_REREAD) || (st == ST_FETCH);
  assign req       = access_st && !wait_q;
  assign accept    = req && ready;
  assign last_idx  = (st == ST_REREAD && width8) ? 2'd3 : 2'd1;

  always_comb begin
    unique case (st)
      ST_DUMMY:  step_addr = DUMMY_ADDR + {29'd0, idx, 1'b0};
      ST_PROBE:  step_addr = VEC_ADDR + {29'd0, idx, 1'b0};
      ST_REREAD: step_addr = width8 ? VEC_ADDR + {30'd0, idx}
                                    : VEC_ADDR + {29'd0, idx, 1'b0};
      ST_FETCH:  step_addr = jump_addr + {29'd0, idx, 1'b0};
      default:   step_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_START;
      run_q     <= ~boot_strap;
      idx       <= '0;
      wait_q    <= 1'b0;
      probe_bit <= 1'b0;
      area_en   <= 1'b0;
      width8    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) wait_q <= 1'b1;
      if (st == ST_START) begin
        if (run_q) begin
          area_en <= 1'b1;
          st      <= ST_DUMMY;
        end else begin
          st <= ST_OFF;
        end
      end else if (access_st && ack) begin
        wait_q <= 1'b0;
        if (st == ST_PROBE && idx == 2'd0) probe_bit <= ack_data[0];
        if (idx == last_idx) begin
          idx <= '0;
          unique case (st)
            ST_DUMMY:  st <= ST_PROBE;
            ST_PROBE: begin
              st     <= ST_REREAD;
              width8 <= probe_bit;
            end
            ST_REREAD: st <= ST_FETCH;
            default: begin
              st   <= ST_DONE;
              done <= 1'b1;
            end
          endcase
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  boot_bus_reader #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LOW_CYC(LOW_CYC)
  ) u_reader (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .req_addr(ADDR_W'(step_addr)),
    .ready   (ready),
    .ack     (ack),
    .ack_data(ack_data),
    .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n),
    .bus_addr(bus_addr),
    .bus_din (bus_din)
  );

  boot_vec_collect #(
    .DATA_W(DATA_W)
  ) u_collect (
    .clk      (clk),
    .rst      (rst),
    .we       (ack && st == ST_REREAD),
    .byte_mode(width8),
    .idx      (idx),
    .din      (ack_data),
    .vec      (jump_addr)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int LOW_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_strap,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              area_en,
  input logic              width8,
  input logic [31:0]       jump_addr,
  input logic              done
);
  logic        strap_hi;
  logic        seen_done;
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_hi  <= boot_strap;
      seen_done <= 1'b0;
      low_run   <= '0;
    end else begin
      seen_done <= seen_done | done;
      if (bus_cs_n) low_run <= '0;
      else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
    end
  end

  // R1
  strap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    strap_hi |-> (bus_cs_n && !done && !area_en));

  // R2
  area_first_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> area_en);

  // R5
  width_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(width8) |-> width8);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  final_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seen_done |-> ($stable(jump_addr) && $stable(width8) && bus_cs_n));

  // R10
  strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n == bus_rd_n);

  // R10
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R10
  low_len_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> (low_run < 16'(LOW_CYC)));
endmodule

bind boot_width_seq boot_seq_chk #(
  .ADDR_W (ADDR_W),
  .LOW_CYC(LOW_CYC)
) u_boot_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .boot_strap(boot_strap),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_addr  (bus_addr),
  .area_en   (area_en),
  .width8    (width8),
  .jump_addr (jump_addr),
  .done      (done)
);

// File: tb/tb_boot_width_seq.sv
module tb_boot_width_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_CYC    = 3;
  localparam int NCASE      = 6;
  // {device is 8-bit, stored vector}
  localparam logic [32:0] CASES [NCASE] = '{
    {1'b1, 32'h1234_5679},
    {1'b0, 32'h8000_ABCE},
    {1'b1, 32'hFFFF_FFFF},
    {1'b0, 32'h0000_0000},
    {1'b1, 32'h0000_0001},
    {1'b0, 32'hFFFF_FFFE}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_strap = 1'b0;
  logic        bus_cs_n, bus_rd_n, area_en, width8, done;
  logic [31:0] bus_addr, jump_addr;
  logic [15:0] bus_din;

  int checks = 0;
  int errors = 0;

  logic        cur_dev8 = 1'b0;
  logic [31:0] cur_vec  = '0;

  logic [31:0] log_addr [16];
  int          nlog = 0, lowc = 0, gap = 0, tbad = 0, abad = 0, done_cnt = 0;
  logic        cs_prev = 1'b1;
  logic [31:0] cur_a = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_width_seq #(.LOW_CYC(LOW_CYC)) dut (
    .clk(clk), .rst(rst), .boot_strap(boot_strap),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
    .bus_din(bus_din), .area_en(area_en), .width8(width8),
    .jump_addr(jump_addr), .done(done)
  );

  function automatic logic [15:0] dev_read(input logic [31:0] a, input logic d8,
                                           input logic [31:0] v);
    logic [7:0] b;
    if (a[31:2] == 30'h0800_0000) begin
      b = v[8*a[1:0] +: 8];
      if (d8) return {8'hA5, b};
      return a[1] ? v[31:16] : v[15:0];
    end
    return d8 ? 16'hA53C : 16'h5A5A;
  endfunction

  assign bus_din = bus_cs_n ? 16'h0000 : dev_read(bus_addr, cur_dev8, cur_vec);

  always @(negedge clk) begin
    if (!bus_cs_n) begin
      if (cs_prev) begin
        if (nlog > 0 && gap != 1) tbad++;
        if (!area_en) abad++;
        if (nlog < 16) log_addr[nlog] = bus_addr;
        nlog++;
        lowc  = 1;
        cur_a = bus_addr;
      end else begin
        lowc++;
        if (bus_addr != cur_a) tbad++;
      end
      if (bus_rd_n) tbad++;
    end else begin
      if (!cs_prev) begin
        if (lowc != LOW_CYC) tbad++;
        gap = 1;
      end else begin
        gap++;
      end
      if (!bus_rd_n) tbad++;
    end
    if (done) done_cnt++;
    cs_prev = bus_cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_addr(input int i, input logic d8,
                                           input logic [31:0] v);
    int re_end;
    re_end = d8 ? 8 : 6;
    if (i < 2) return 32'h00C0_0000 + 32'(2 * i);
    if (i < 4) return 32'h2000_0000 + 32'(2 * (i - 2));
    if (i < re_end) return d8 ? 32'h2000_0000 + 32'(i - 4)
                              : 32'h2000_0000 + 32'(2 * (i - 4));
    return v + 32'(2 * (i - re_end));
  endfunction

  function automatic string tag_of(input int i, input logic d8);
    if (i < 2) return "R3";
    if (i < 4) return "R4";
    if (i < (d8 ? 8 : 6)) return d8 ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic clear_mon();
    nlog = 0; tbad = 0; abad = 0; done_cnt = 0; gap = 0;
  endtask

  task automatic run_boot(input logic d8, input logic [31:0] v, input bit aborted);
    int n_exp, waited;
    logic [31:0] held;
    cur_dev8 = d8; cur_vec = v; boot_strap = 1'b0;
    rst = 1'b1;
    tick(2);
    clear_mon();
    rst = 1'b0;
    waited = 0;
    while (done_cnt == 0 && waited < 400) begin tick(1); waited++; end
    held = jump_addr;
    tick(12);
    n_exp = d8 ? 10 : 8;
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(nlog == n_exp, "R3 R8 access count", nlog, n_exp);
    for (int i = 0; i < n_exp && i < nlog; i++)
      chk(log_addr[i] == exp_addr(i, d8, v), tag_of(i, d8), log_addr[i],
          exp_addr(i, d8, v));
    if (aborted)
      chk(nlog > 0 && log_addr[0] == 32'h00C0_0000, "R11 restart address",
          log_addr[0], 32'h00C0_0000);
    chk(width8 == d8, "R5 width8", width8, d8);
    chk(jump_addr == v, d8 ? "R6 target" : "R7 target", jump_addr, v);
    chk(jump_addr == held, "R9 target held", jump_addr, held);
    chk(tbad == 0, "R10 strobe timing", tbad, 0);
    chk(abad == 0, "R2 area enabled first", abad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R2)
    rst = 1'b1; boot_strap = 1'b0;
    tick(3);
    chk(bus_cs_n && bus_rd_n, "R2 reset strobes", {bus_cs_n, bus_rd_n}, 2'b11);
    chk(!width8, "R2 reset width", width8, 0);
    chk(!area_en, "R2 reset area_en", area_en, 0);
    chk(!done, "R2 reset done", done, 0);

    // Vector table
    for (int k = 0; k < NCASE; k++)
      run_boot(CASES[k][32], CASES[k][31:0], 1'b0);

    // R11: reset during the re-read, then a full run
    cur_dev8 = 1'b1; cur_vec = 32'hCAFE_0E01; boot_strap = 1'b0;
    rst = 1'b1; tick(2); clear_mon(); rst = 1'b0;
    for (int w = 0; w < 200 && nlog < 6; w++) tick(1);
    run_boot(1'b0, 32'h0BAD_F00C, 1'b1);

    // R1: strap high during reset, then strap low afterwards
    boot_strap = 1'b1; rst = 1'b1; tick(2); clear_mon(); rst = 1'b0;
    tick(40);
    boot_strap = 1'b0;
    tick(60);
    chk(nlog == 0, "R1 no bus cycles", nlog, 0);
    chk(done_cnt == 0, "R1 no done", done_cnt, 0);
    chk(!area_en, "R1 area_en", area_en, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule